// File: doc/BRIEF.md
# Multiplexed Channel Readout Scanner

This block drives a four-digit, common-anode seven-segment display from a small file of eight 8-bit readings. It visits the readings one at a time. While a reading is on display, three digits show it in decimal (hundreds, tens and ones, with leading zeros) and the fourth digit shows which of the eight channels it came from. The digits are lit one after another, with a short dark gap between them. Each reading stays on display for a fixed number of complete four-digit rounds. After the last channel, the scan returns to the first.

Readings enter through a write port into an internal value file, which is written so that it can map to block RAM. The block copies a channel's reading once, at the first cycle of that channel's dwell. It splits the copy into decimal digits with a divide by one hundred, followed by a divide by ten of the remainder. All outputs are registered and active-low.

Top module: `disp_channel_scan`

## Requirements
- R1: While `rst` is high, and at the first clock edge after it falls, `seg_n` is 8'hFF and `dig_sel_n` is 4'hF.
- R2: For a shown reading v, digit 2 shows v/100, digit 1 shows (v mod 100)/10 and digit 0 shows v mod 10. Leading zeros are shown as the code for 0.
- R3: Digit 3 shows the index of the channel currently on display, from 0 to 7.
- R4: While a digit is lit, exactly one `dig_sel_n` bit is low: 4'b1110 selects digit 0, 4'b1101 digit 1, 4'b1011 digit 2 and 4'b0111 digit 3. Digits are lit in that order within every round.
- R5: Segment codes on `seg_n` (bit 0 = segment a through bit 6 = segment g, bit 7 = point, always 1) for the values 0 to 9 are C0, F9, A4, B0, 99, 92, 82, F8, 80 and 90 in hex, and FF means dark.
- R6: Number the clock edges from 0, starting at the first edge with `rst` low, and let SLOT = BLANK_TICKS + DIGIT_TICKS. The outputs after edge k belong to digit (k/SLOT) mod 4. They are dark (`seg_n` = FF, `dig_sel_n` = F) when k mod SLOT < BLANK_TICKS, and lit otherwise.
- R7: Each channel stays on display for ROUNDS complete rounds (4·SLOT·ROUNDS edges). The channel after edge k is (k/(4·SLOT·ROUNDS)) mod 8, so channel 7 is followed by channel 0.
- R8: A channel's reading is copied at the first edge of its dwell. A write to that channel later in the dwell leaves the shown digits unchanged.
- R9: If a write to a channel lands on the same edge as that channel's copy, the previous contents are shown for that dwell.
- R10: A write on `wr_en` stores `wr_data` at `wr_addr`, and the stored value is shown at that channel's next dwell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Value file write strobe |
| wr_addr | input | 3 | Channel written |
| wr_data | input | 8 | Reading written |
| seg_n | output | 8 | Active-low segment bus, bit 0 = a ... bit 6 = g, bit 7 = point |
| dig_sel_n | output | 4 | Active-low digit select, bit i lights digit i |

## Verification
The copy of a reading at the start of a dwell and a write into the value file can fall on the same edge, and the write can even target the very entry being copied. The bench forces this on purpose: it writes a changed value into the entry that is about to be shown, exactly on that channel's first dwell edge. It expects the old value for the whole dwell and the new value at the next visit. Random writes at other times, including writes into the channel on display, are judged by a bench model that copies its own file image at the same edges and predicts every output cycle by cycle.

// File: rtl/disp_pkg.sv
package disp_pkg;

  localparam logic [7:0] SEG_DARK = 8'hFF;

  // Active-low seven-segment pattern, bit 0 = a ... bit 6 = g, bit 7 = point.
  function automatic logic [7:0] seg_code(input logic [3:0] val);
    logic [7:0] s;
    case (val)
      4'd0: s = 8'hC0;
      4'd1: s = 8'hF9;
      4'd2: s = 8'hA4;
      4'd3: s = 8'hB0;
      4'd4: s = 8'h99;
      4'd5: s = 8'h92;
      4'd6: s = 8'h82;
      4'd7: s = 8'hF8;
      4'd8: s = 8'h80;
      4'd9: s = 8'h90;
      default: s = SEG_DARK;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/disp_value_file.sv
module disp_value_file #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // Read-before-write: a same-edge write is not seen by this read.
  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/disp_bcd_split.sv
module disp_bcd_split #(
  parameter int VAL_W = 8
) (
  input  logic [VAL_W-1:0] value,
  output logic [3:0]       hund,
  output logic [3:0]       tens,
  output logic [3:0]       ones
);

  logic [VAL_W-1:0] rest;

  always_comb begin
    hund = 4'(value / VAL_W'(100));
    rest = value % VAL_W'(100);
    tens = 4'(rest / VAL_W'(10));
    ones = 4'(rest % VAL_W'(10));
  end

endmodule

// File: rtl/disp_scan_timer.sv
module disp_scan_timer #(
  parameter int NUM_CH      = 8,
  parameter int NUM_DIGITS  = 4,
  parameter int ROUNDS      = 255,
  parameter int DIGIT_TICKS = 50000,
  parameter int BLANK_TICKS = 16,
  localparam int CH_W = $clog2(NUM_CH),
  localparam int DG_W = $clog2(NUM_DIGITS)
) (
  input  logic            clk,
  input  logic            rst,
  output logic [CH_W-1:0] chan,
  output logic [DG_W-1:0] digit,
  output logic            lit,
  output logic            load
);

  localparam int SLOT   = BLANK_TICKS + DIGIT_TICKS;
  localparam int TICK_W = $clog2(SLOT + 1);
  localparam int RND_W  = $clog2(ROUNDS + 1);

  logic [TICK_W-1:0] tick;
  logic [RND_W-1:0]  round;
  logic              slot_end, round_end, dwell_end;

  assign slot_end  = (tick == TICK_W'(SLOT - 1));
  assign round_end = slot_end && (digit == DG_W'(NUM_DIGITS - 1));
  assign dwell_end = round_end && (round == RND_W'(ROUNDS - 1));
  assign lit       = (tick >= TICK_W'(BLANK_TICKS));
  assign load      = (tick == '0) && (digit == '0) && (round == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      tick  <= '0;
      digit <= '0;
      round <= '0;
      chan  <= '0;
    end else begin
      tick <= slot_end ? '0 : tick + 1'b1;
      if (slot_end)
        digit <= round_end ? '0 : digit + 1'b1;
      if (round_end)
        round <= dwell_end ? '0 : round + 1'b1;
      if (dwell_end)
        chan <= (chan == CH_W'(NUM_CH - 1)) ? '0 : chan + 1'b1;
    end
  end

  AST_CH_WRAP: assert property (@(posedge clk) disable iff (rst)
    ($past(chan) == CH_W'(NUM_CH - 1) && chan != $past(chan)) |-> chan == '0); // R7

  AST_CH_STEP_AT_START: assert property (@(posedge clk) disable iff (rst)
    (chan != $past(chan)) |-> (tick == '0 && digit == '0 && round == '0)); // R7

endmodule

// File: rtl/disp_channel_scan.sv
module disp_channel_scan #(
  parameter int NUM_CH      = 8,
  parameter int VAL_W       = 8,
  parameter int ROUNDS      = 255,
  parameter int DIGIT_TICKS = 50000,
  parameter int BLANK_TICKS = 16,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CH_W-1:0]  wr_addr,
  input  logic [VAL_W-1:0] wr_data,
  output logic [7:0]       seg_n,
  output logic [3:0]       dig_sel_n
);

  import disp_pkg::*;

  localparam int NUM_DIGITS = 4;
  localparam int DG_W = $clog2(NUM_DIGITS);

  logic [CH_W-1:0]  chan;
  logic [DG_W-1:0]  digit;
  logic             lit, load;
  logic [VAL_W-1:0] shown;
  logic [3:0]       hund, tens, ones;
  logic [3:0]       dig_val [NUM_DIGITS];

  disp_scan_timer #(
    .NUM_CH(NUM_CH), .NUM_DIGITS(NUM_DIGITS), .ROUNDS(ROUNDS),
    .DIGIT_TICKS(DIGIT_TICKS), .BLANK_TICKS(BLANK_TICKS)
  ) timer_i (
    .clk(clk), .rst(rst), .chan(chan), .digit(digit), .lit(lit), .load(load)
  );

  disp_value_file #(.DEPTH(NUM_CH), .WIDTH(VAL_W)) vfile_i (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(load), .rd_addr(chan), .rd_data(shown)
  );

  disp_bcd_split #(.VAL_W(VAL_W)) split_i (
    .value(shown), .hund(hund), .tens(tens), .ones(ones)
  );

  assign dig_val[0] = ones;
  assign dig_val[1] = tens;
  assign dig_val[2] = hund;
  assign dig_val[3] = 4'(chan);

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_n     <= SEG_DARK;
      dig_sel_n <= 4'hF;
    end else if (lit) begin
      seg_n     <= seg_code(dig_val[digit]);
      dig_sel_n <= ~(4'b0001 << digit);
    end else begin
      seg_n     <= SEG_DARK;
      dig_sel_n <= 4'hF;
    end
  end

  AST_ONE_DIGIT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~dig_sel_n)); // R4

  AST_DARK_WHEN_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (dig_sel_n == 4'hF) |-> (seg_n == SEG_DARK)); // R6

  AST_GAP_BETWEEN_DIGITS: assert property (@(posedge clk) disable iff (rst)
    (dig_sel_n != 4'hF && $past(dig_sel_n) != 4'hF) |-> $stable(dig_sel_n)); // R6

  AST_HOLD_MIDDWELL: assert property (@(posedge clk) disable iff (rst)
    !$past(load) |-> $stable(shown)); // R8

  AST_BCD_RECOMBINE: assert property (@(posedge clk) disable iff (rst)
    (tens <= 4'd9 && ones <= 4'd9 &&
     (int'(hund) * 100 + int'(tens) * 10 + int'(ones)) == int'(shown))); // R2

endmodule

// File: tb/disp_channel_scan_tb.sv
module disp_channel_scan_tb_top;

  localparam int NCH   = 8;
  localparam int DT    = 4;
  localparam int BT    = 1;
  localparam int RND   = 3;
  localparam int SLOT  = DT + BT;
  localparam int CHCYC = 4 * SLOT * RND;
  localparam int TOTAL = 2 * NCH * CHCYC + 7;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] seg_n;
  logic [3:0] dig_sel_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int ref_mem [NCH];
  int shown;
  int dec [4];
  string dwell_tag;

  always #10 clk = ~clk;  // 50 MHz

  disp_channel_scan #(
    .NUM_CH(NCH), .VAL_W(8), .ROUNDS(RND), .DIGIT_TICKS(DT), .BLANK_TICKS(BT)
  ) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .seg_n(seg_n), .dig_sel_n(dig_sel_n)
  );

  function automatic int exp_seg(input int d);
    case (d)
      0: return 'hC0;  1: return 'hF9;  2: return 'hA4;  3: return 'hB0;
      4: return 'h99;  5: return 'h92;  6: return 'h82;  7: return 'hF8;
      8: return 'h80;  9: return 'h90;
      default: return 'hFF;
    endcase
  endfunction

  function automatic int seg_to_val(input logic [7:0] s);
    for (int d = 0; d < 10; d++)
      if (int'(s) == exp_seg(d)) return d;
    return -1;
  endfunction

  function automatic int digit_of(input int v, input int dg, input int ch);
    case (dg)
      0: return v % 10;
      1: return (v / 10) % 10;
      2: return v / 100;
      default: return ch;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h time=%0t", tag, act, exp, $time);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    ref_mem[0] = 0;   ref_mem[1] = 255; ref_mem[2] = 100; ref_mem[3] = 99;
    ref_mem[4] = 9;   ref_mem[5] = 10;  ref_mem[6] = 199; ref_mem[7] = 7;
    // load the file during reset (R10)
    for (int i = 0; i < NCH; i++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 3'(i); wr_data = 8'(ref_mem[i]);
    end
    @(negedge clk);
    wr_en = 1'b0;
    chk("R1", int'(seg_n), 'hFF);
    chk("R1", int'(dig_sel_n), 'hF);
    shown = ref_mem[0];
    dwell_tag = "";
    rst = 1'b0;
    for (int k = 0; k < TOTAL; k++) begin
      @(negedge clk);
      begin
        int p, dg, ch, e, ech, dv;
        string tag;
        p  = k % SLOT;
        dg = (k / SLOT) % 4;
        ch = (k / CHCYC) % NCH;
        if (k == 0) begin
          chk("R1", int'(seg_n), 'hFF);
          chk("R1", int'(dig_sel_n), 'hF);
        end
        if (p < BT) begin
          chk("R6", int'(seg_n), 'hFF);
          chk("R6", int'(dig_sel_n), 'hF);
        end else begin
          dv  = digit_of(shown, dg, ch);
          tag = (dwell_tag != "") ? dwell_tag : ((dg == 3) ? "R3" : "R2");
          chk("R4", int'(dig_sel_n), (~(1 << dg)) & 'hF);
          chk(tag, int'(seg_n), exp_seg(dv));
          dec[dg] = seg_to_val(seg_n);
        end
        if (k % CHCYC == CHCYC - 1) begin
          chk("R5", dec[0] + 10 * dec[1] + 100 * dec[2], shown);
          chk("R5", dec[3], ch);
        end
        // plan stimulus for edge e = k+1
        e   = k + 1;
        ech = (e / CHCYC) % NCH;
        wr_en = 1'b0;
        if (e % CHCYC == 0) begin
          shown = ref_mem[ech];
          if (e / CHCYC >= NCH) dwell_tag = (ech == 0) ? "R7" : "R10";
          else dwell_tag = "";
          if (e == 3 * CHCYC || e == 14 * CHCYC) begin
            // same-edge write into the entry being copied (R9)
            wr_en = 1'b1; wr_addr = 3'(ech);
            wr_data = 8'(ref_mem[ech] ^ 'h5A);
            ref_mem[ech] = ref_mem[ech] ^ 'h5A;
            dwell_tag = "R9";
          end
        end else if (($urandom % 4) == 0 || (e % CHCYC) == 30) begin
          int a, v;
          a = ((e % CHCYC) == 30) ? ech : int'($urandom % NCH);
          v = int'($urandom % 256);
          if ((e % CHCYC) == 30 && (e / CHCYC) == 1) v = 255;
          wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(v);
          ref_mem[a] = v;
          if (a == ech && dwell_tag != "R9") dwell_tag = "R8";
        end
      end
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R6 watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule